// File: doc/BRIEF.md
# Flash Converter Digital Back End

This block is the digital half of a 6-bit flash analog-to-digital converter. It takes the latched decisions of the converter's comparator bank and turns them into a binary sample word and an over-range flag. The bank has one comparator per threshold for the 63 thresholds of the transfer curve, plus one more comparator above full scale. The word is built in two pipeline stages. Those stages run on a two-phase timing signal made from the input clock and a phase-select pin. A sample reaches the outputs one and a half clock cycles after it was taken.

The output side models three-state pins as a value plus a drive flag. The six data bits and the over-range flag have separate drive flags, so that a higher level can keep the flag on a shared bus while the data bits float. That use case is joining two converters into one of higher resolution.

The block streams one result per clock with no handshake. It applies no back-pressure, and a result that nobody reads is simply replaced one cycle later. Comparator decisions come in as a plain 64-bit vector.

Top module: `flash_backend`

## Requirements
- R1: Bit j of `comp_i` (j = 0..62) is the comparator for threshold j+1. For a clean thermometer pattern with k of those bits set from bit 0 upward and bit 63 clear, `code_o` equals k and `ovf_o` is 0.
- R2: Bit 63 of `comp_i` is the over-range comparator. When it is set, `code_o` reads 63 (all ones) and `ovf_o` reads 1, whatever the lower bits hold.
- R3: With no comparator set, `code_o` is 0 and `ovf_o` is 0.
- R4: When a pattern has gaps (a clear bit below a set bit), `code_o` is one more than the index of the highest set bit among bits 0..62. It is never larger than that.
- R5: The internal timing signal is `clk` XOR `phase_sel`. The sample phase is when `clk` equals `phase_sel`, and the balance phase is otherwise. Comparator data is captured at the moment the sample phase ends.
- R6: A vector captured at the end of a sample phase appears on `code_o`/`ovf_o` at the start of the sample phase that begins one and a half clock cycles later. It then holds for one full clock cycle.
- R7: With `bus_en`=1 and `data_mute`=0, both `data_oe` and `ovf_oe` are 1.
- R8: With `bus_en`=1 and `data_mute`=1, `data_oe` is 0 and `ovf_oe` is 1.
- R9: With `bus_en`=0, `data_oe` and `ovf_oe` are both 0, whatever `data_mute` holds.
- R10: While the synchronous active-high `rst` is held, the outputs read `code_o`=0 and `ovf_o`=0, even with every comparator set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| phase_sel | input | 1 | Selects which clock level is the sample phase |
| rst | input | 1 | Synchronous reset, active high |
| comp_i | input | 64 | Comparator decisions; bit 63 is the over-range comparator |
| bus_en | input | 1 | Master drive enable for all outputs, active high |
| data_mute | input | 1 | Floats the six data bits while high |
| code_o | output | 6 | Encoded sample word |
| ovf_o | output | 1 | Over-range flag |
| data_oe | output | 1 | Drive flag for `code_o` |
| ovf_oe | output | 1 | Drive flag for `ovf_o` |

## Verification
The bench builds the block with its default parameters: 6 result bits and groups of 8 comparators, which gives 8 groups. Sweeping comparator counts from 0 to 64 therefore crosses every group boundary of the two-stage priority search, as well as the all-clear and over-range ends. The same sweep runs with both settings of the phase pin, so capture on either clock edge and the half-cycle offset are both exercised. Patterns with gaps are checked against the highest-set rule.

// File: rtl/flash_be_pkg.sv
package flash_be_pkg;
  // Level of the derived timing signal.
  typedef enum logic {
    PH_SAMPLE  = 1'b0,
    PH_BALANCE = 1'b1
  } phase_e;
endpackage

// File: rtl/flash_phase_gen.sv
module flash_phase_gen
  import flash_be_pkg::*;
(
  input  logic clk,
  input  logic phase_sel,
  output logic ph
);
  phase_e cur;
  // Sample while clk equals phase_sel; balance otherwise.
  assign cur = phase_e'(clk ^ phase_sel);
  assign ph  = (cur == PH_BALANCE);
endmodule

// File: rtl/flash_group_stage.sv
// First encode stage: captured as the balance phase begins.
// Splits the level vector into groups and finds the top set bit of each.
module flash_group_stage #(
  parameter int unsigned RES      = 6,
  parameter int unsigned GRP_BITS = 3,
  localparam int unsigned LEVELS  = 1 << RES,
  localparam int unsigned GRP     = 1 << GRP_BITS,
  localparam int unsigned NGRP    = LEVELS / GRP
) (
  input  logic                              ph,
  input  logic                              rst,
  input  logic [LEVELS-1:0]                 comp,
  output logic [NGRP-1:0]                   grp_any_q,
  output logic [NGRP-1:0][GRP_BITS-1:0]     grp_idx_q,
  output logic                              ovf_q
);
  logic [LEVELS-1:0]                ext;
  logic [NGRP-1:0]                  any_d;
  logic [NGRP-1:0][GRP_BITS-1:0]    idx_d;

  // Position 0 is always "reached"; position p is threshold p.
  assign ext = {comp[LEVELS-2:0], 1'b1};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP-1:0] slice;
    assign slice    = ext[g*GRP +: GRP];
    assign any_d[g] = |slice;
    always_comb begin
      idx_d[g] = '0;
      for (int j = 0; j < GRP; j++)
        if (slice[j]) idx_d[g] = GRP_BITS'(j);
    end
  end

  always_ff @(posedge ph) begin
    if (rst) begin
      grp_any_q <= '0;
      grp_idx_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      grp_any_q <= any_d;
      grp_idx_q <= idx_d;
      ovf_q     <= comp[LEVELS-1];
    end
  end

  // R3: the base group always holds the zero position after a capture.
  p_base_group_r3: assert property (@(posedge ph) disable iff (rst)
    !rst |=> grp_any_q[0]);
endmodule

// File: rtl/flash_merge_stage.sv
// Second encode stage: completes on the sample phase that follows.
module flash_merge_stage #(
  parameter int unsigned RES      = 6,
  parameter int unsigned GRP_BITS = 3,
  localparam int unsigned NGRP    = (1 << RES) >> GRP_BITS,
  localparam int unsigned NG_BITS = RES - GRP_BITS
) (
  input  logic                              ph,
  input  logic                              rst,
  input  logic [NGRP-1:0]                   grp_any,
  input  logic [NGRP-1:0][GRP_BITS-1:0]     grp_idx,
  input  logic                              ovf_in,
  output logic [RES-1:0]                    code_q,
  output logic                              ovf_q
);
  logic [RES-1:0] code_d;

  always_comb begin
    code_d = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp_any[g]) code_d = {NG_BITS'(g), grp_idx[g]};
    if (ovf_in) code_d = '1;
  end

  always_ff @(negedge ph) begin
    if (rst) begin
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      ovf_q  <= ovf_in;
    end
  end

  // R2: an over-range capture yields a saturated word with the flag.
  p_ovf_saturate_r2: assert property (@(negedge ph) disable iff (rst)
    ovf_in |=> (code_q == {RES{1'b1}}) && ovf_q);
endmodule

// File: rtl/flash_backend.sv
module flash_backend #(
  parameter int unsigned RES      = 6,
  parameter int unsigned GRP_BITS = 3,
  localparam int unsigned LEVELS  = 1 << RES,
  localparam int unsigned NGRP    = LEVELS >> GRP_BITS
) (
  input  logic              clk,
  input  logic              phase_sel,
  input  logic              rst,
  input  logic [LEVELS-1:0] comp_i,
  input  logic              bus_en,
  input  logic              data_mute,
  output logic [RES-1:0]    code_o,
  output logic              ovf_o,
  output logic              data_oe,
  output logic              ovf_oe
);
  logic                          ph;
  logic [NGRP-1:0]               grp_any;
  logic [NGRP-1:0][GRP_BITS-1:0] grp_idx;
  logic                          ovf_s1;
  logic [RES-1:0]                code_s2;
  logic                          ovf_s2;

  flash_phase_gen u_phase (
    .clk       (clk),
    .phase_sel (phase_sel),
    .ph        (ph)
  );

  flash_group_stage #(.RES(RES), .GRP_BITS(GRP_BITS)) u_grp (
    .ph        (ph),
    .rst       (rst),
    .comp      (comp_i),
    .grp_any_q (grp_any),
    .grp_idx_q (grp_idx),
    .ovf_q     (ovf_s1)
  );

  flash_merge_stage #(.RES(RES), .GRP_BITS(GRP_BITS)) u_merge (
    .ph      (ph),
    .rst     (rst),
    .grp_any (grp_any),
    .grp_idx (grp_idx),
    .ovf_in  (ovf_s1),
    .code_q  (code_s2),
    .ovf_q   (ovf_s2)
  );

  // Output register: loads as the next sample phase begins (1.5 cycles).
  always_ff @(negedge ph) begin
    if (rst) begin
      code_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      code_o <= code_s2;
      ovf_o  <= ovf_s2;
    end
  end

  // Drive flags follow the enables with no register.
  assign ovf_oe  = bus_en;
  assign data_oe = bus_en & ~data_mute;

  p_ovf_full_r2: assert property (@(negedge ph) disable iff (rst)
    ovf_o |-> (code_o == {RES{1'b1}}));
  p_mute_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_en && data_mute) |-> (ovf_oe && !data_oe));
  p_bus_off_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> (!data_oe && !ovf_oe));
endmodule

// File: tb/flash_backend_bench.sv
`timescale 1ns/1ps
module flash_backend_bench;
  logic        clk = 1'b0;
  logic        phase_sel = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] comp = '0;
  logic        bus_en = 1'b0;
  logic        data_mute = 1'b0;
  logic [5:0]  code_o;
  logic        ovf_o, data_oe, ovf_oe;
  logic        ph_b;

  typedef struct {
    logic [5:0] code;
    logic       ovf;
    int         tag;   // 1:R1 2:R2 3:R3 4:R4
  } exp_t;

  exp_t q[$];
  bit   mon_en = 1'b0;
  int   checks = 0;
  int   fails  = 0;

  flash_backend u_flash_backend (
    .clk(clk), .phase_sel(phase_sel), .rst(rst), .comp_i(comp),
    .bus_en(bus_en), .data_mute(data_mute),
    .code_o(code_o), .ovf_o(ovf_o), .data_oe(data_oe), .ovf_oe(ovf_oe)
  );

  always #2.5 clk = ~clk;
  // R5: balance phase when clk differs from phase_sel.
  assign ph_b = clk ^ phase_sel;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic exp_t model(logic [63:0] v, bit bubble);
    exp_t e;
    e.code = '0; e.ovf = 1'b0;
    for (int i = 0; i < 63; i++) if (v[i]) e.code = 6'(i + 1);
    if (v[63]) begin e.code = 6'd63; e.ovf = 1'b1; end
    e.tag = e.ovf ? 2 : (e.code == 0) ? 3 : bubble ? 4 : 1;
    return e;
  endfunction

  function automatic logic [63:0] therm(int k);
    logic [63:0] v = '0;
    for (int i = 0; i < 64; i++) if (i < k) v[i] = 1'b1;
    return v;
  endfunction

  // Driver: new vector each sample phase, expected value into the queue.
  task automatic apply(logic [63:0] v, bit bubble);
    @(negedge ph_b);
    #1;
    comp = v;
    q.push_back(model(v, bubble));
    mon_en = 1'b1;
  endtask

  // Monitor: output seen after edge n reflects the vector driven after edge n-2 (R6).
  always @(negedge ph_b) begin
    #2;
    if (mon_en && q.size() == 3) begin
      exp_t e;
      string req;
      e = q.pop_front();
      case (e.tag)
        2: req = "R2 R6 R5";
        3: req = "R3 R6 R5";
        4: req = "R4 R6 R5";
        default: req = "R1 R6 R5";
      endcase
      chk({ovf_o, code_o} == {e.ovf, e.code}, req,
          int'({ovf_o, code_o}), int'({e.ovf, e.code}));
    end
  end

  task automatic do_reset(bit p);
    mon_en = 1'b0;
    @(negedge ph_b);
    #1;
    rst = 1'b1;
    comp = '1;
    phase_sel = p;
    repeat (4) @(posedge clk);
    #1;
    chk(code_o == 6'd0 && ovf_o == 1'b0, "R10 reset", int'({ovf_o, code_o}), 0);
    q.delete();
    @(negedge ph_b);
    #1;
    rst = 1'b0;
  endtask

  task automatic oe_chk(bit be, bit dm, bit exp_d, bit exp_o, string req);
    bus_en = be; data_mute = dm;
    #1;
    chk(data_oe == exp_d && ovf_oe == exp_o, req,
        int'({data_oe, ovf_oe}), int'({exp_d, exp_o}));
  endtask

  task automatic run_suite();
    int dir[8] = '{0, 1, 16, 32, 48, 62, 63, 64};
    foreach (dir[i]) apply(therm(dir[i]), 1'b0);   // R1 R2 R3 edges
    for (int n = 0; n < 300; n++) apply(therm($urandom_range(64, 0)), 1'b0);
    for (int n = 0; n < 100; n++) begin            // R4 gaps
      int k = $urandom_range(63, 3);
      logic [63:0] v = therm(k);
      v[$urandom_range(k - 2, 0)] = 1'b0;
      apply(v, 1'b1);
    end
    // over-range with gaps below still saturates (R2)
    apply(64'h8000_0000_0000_0001, 1'b0);
    apply(64'h8000_0000_0000_0000, 1'b0);
    apply('0, 1'b0);
    apply('0, 1'b0);
    apply('0, 1'b0);
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    oe_chk(1'b1, 1'b0, 1'b1, 1'b1, "R7 both driven");
    oe_chk(1'b1, 1'b1, 1'b0, 1'b1, "R8 data floated");
    oe_chk(1'b0, 1'b0, 1'b0, 1'b0, "R9 all floated");
    oe_chk(1'b0, 1'b1, 1'b0, 1'b0, "R9 all floated mute");
    oe_chk(1'b1, 1'b0, 1'b1, 1'b1, "R7 restore");
    run_suite();
    do_reset(1'b1);      // R5 with sample on the high clock level
    run_suite();
    do_reset(1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule